// File: doc/BRIEF.md
# Byte-lane host bus to word port bridge

This block is the device end of a narrow host bus. The host owns the bus clock and drives an address strobe, a data strobe, a direction line and a byte lane. The block collects a 16-bit word address from two address beats. It then assembles 32-bit write words from four data beats, or serialises 32-bit read words into four data beats, on a simple internal word port. After every complete word the word address steps by one, so a burst of words needs only one address phase.

All capture happens on the falling edge of the bus clock. The byte the block returns is updated on the rising edge. The internal port runs in the same clock domain. The host bus cannot be stalled, so neither side of the word port has back-pressure. A write is a single-cycle strobe that the port must accept. Read data must follow `rd_addr` combinationally and stay valid for as long as that address is held. The byte lane is split into `bus_din`, `bus_dout` and `bus_oe` so that the pad buffer sits outside the block.

Top module: `pbs_bridge`

## Requirements
- R1: While `rst_n` is low, `bus_oe`, `wr_stb` and `rd_en` are 0, and `rd_addr`, `wr_addr`, `wr_data` and `bus_dout` are 0.
- R2: Two consecutive falling-edge captures with `bus_asel` high load the word address, high byte first. The address appears on `rd_addr` after the second capture. A third consecutive address beat starts a new two-beat address phase.
- R3: With `bus_we` high, four data beats (`bus_dsel` high, `bus_asel` low) form a word, most significant byte first. `wr_stb` is high for exactly the one cycle after the fourth capture, with that word on `wr_data` and the word address on `wr_addr`.
- R4: After every fourth data beat, read or write, the word address increments by one and wraps from 0xFFFF to 0x0000.
- R5: `rd_en` pulses for one cycle after an address phase that completes with `bus_we` low, and again after each fourth read beat.
- R6: On a read beat, the block presents on `bus_dout` the byte of `rd_data` selected by the beat index, byte 31:24 first. The value is updated on the rising edge that comes before the capturing falling edge.
- R7: `bus_oe` is high exactly when `bus_dsel` is high, `bus_we` is low and `bus_asel` is low.
- R8: An address beat clears the beat counter. A partly transferred word is dropped, and the next four data beats form a complete new word.
- R9: When `bus_asel` and `bus_dsel` are both high, the beat is treated as an address beat.
- R10: `wr_stb` and `rd_en` are never high in the same cycle, and `wr_stb` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host-driven bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_asel | input | 1 | Address beat strobe |
| bus_dsel | input | 1 | Data beat strobe |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_din | input | 8 | Byte lane, host to block |
| bus_dout | output | 8 | Byte lane, block to host |
| bus_oe | output | 1 | Drive enable for the byte lane pad |
| wr_stb | output | 1 | Word write strobe, one cycle |
| wr_addr | output | 16 | Word address of the write |
| wr_data | output | 32 | Assembled write word |
| rd_en | output | 1 | Read issue pulse |
| rd_addr | output | 16 | Current word address for reads |
| rd_data | input | 32 | Read word for `rd_addr`, combinational |

## Verification
On every cycle the assertions check several local properties. The address step after each word and the low address byte after an address phase are checked. So are the beat counter clearing on an address beat, the single-cycle write strobe, exclusion between write strobe and read issue, and the lane staying undriven during writes. The byte order on the lane, complete burst sequences, the wrap at the top of the address space, dropping a partial word and strobe priority can only be shown by the bench's scenarios. There, a behavioural model of the protocol predicts every output on every clock.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  parameter int unsigned LANE_W = 8;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned BEATS  = 4;
  localparam int unsigned WORD_W = LANE_W * BEATS;
  localparam int unsigned BEAT_W = $clog2(BEATS);
endpackage

// File: rtl/pbs_addr_phase.sv
module pbs_addr_phase #(
  parameter int unsigned LANE_W = pbs_pkg::LANE_W,
  parameter int unsigned ADDR_W = pbs_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asel,
  input  logic [LANE_W-1:0] din,
  input  logic              inc,
  output logic [ADDR_W-1:0] word_addr,
  output logic              addr_done
);
  localparam int unsigned ABYTES = ADDR_W / LANE_W;
  localparam int unsigned ACNT_W = (ABYTES > 1) ? $clog2(ABYTES) : 1;

  logic [ACNT_W-1:0] acnt;
  logic [ADDR_W-1:0] acc;

  assign addr_done = asel && (acnt == ACNT_W'(ABYTES - 1));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt      <= '0;
      acc       <= '0;
      word_addr <= '0;
    end else if (asel) begin
      acc <= {acc[ADDR_W-LANE_W-1:0], din};
      if (addr_done) begin
        word_addr <= {acc[ADDR_W-LANE_W-1:0], din};
        acnt      <= '0;
      end else begin
        acnt <= acnt + 1'b1;
      end
    end else begin
      acnt <= '0;
      if (inc) word_addr <= word_addr + 1'b1;
    end
  end

  // R4
  inc_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (inc && !asel) |=> word_addr == ADDR_W'($past(word_addr) + 1'b1));

  // R2
  addr_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    addr_done |=> word_addr[LANE_W-1:0] == $past(din));
endmodule

// File: rtl/pbs_beat_unit.sv
module pbs_beat_unit #(
  parameter int unsigned LANE_W = pbs_pkg::LANE_W,
  parameter int unsigned ADDR_W = pbs_pkg::ADDR_W,
  parameter int unsigned BEATS  = pbs_pkg::BEATS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       asel,
  input  logic                       dsel,
  input  logic                       we,
  input  logic [LANE_W-1:0]          din,
  input  logic [ADDR_W-1:0]          word_addr,
  output logic [$clog2(BEATS)-1:0]   beat,
  output logic                       word_done,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [LANE_W*BEATS-1:0]    wr_data
);
  localparam int unsigned BEAT_W = $clog2(BEATS);
  localparam int unsigned WORD_W = LANE_W * BEATS;

  logic [WORD_W-LANE_W-1:0] wbuf;
  logic                     data_beat;

  assign data_beat = dsel && !asel;
  assign word_done = data_beat && (beat == BEAT_W'(BEATS - 1));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat    <= '0;
      wbuf    <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (asel) begin
        beat <= '0;
      end else if (dsel) begin
        beat <= word_done ? '0 : beat + 1'b1;
        if (we) begin
          wbuf <= {wbuf[WORD_W-2*LANE_W-1:0], din};
          if (word_done) begin
            wr_stb  <= 1'b1;
            wr_data <= {wbuf, din};
            wr_addr <= word_addr;
          end
        end
      end
    end
  end

  // R8
  beat_clear_chk: assert property (@(negedge clk) disable iff (!rst_n)
    asel |=> beat == '0);

  // R3
  strobe_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/pbs_lane_drv.sv
module pbs_lane_drv #(
  parameter int unsigned LANE_W = pbs_pkg::LANE_W,
  parameter int unsigned BEATS  = pbs_pkg::BEATS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     asel,
  input  logic                     dsel,
  input  logic                     we,
  input  logic [$clog2(BEATS)-1:0] beat,
  input  logic [LANE_W*BEATS-1:0]  rd_data,
  output logic [LANE_W-1:0]        dout,
  output logic                     oe
);
  localparam int unsigned WORD_W = LANE_W * BEATS;

  logic [LANE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < BEATS; i++) begin
      if (int'(beat) == i) sel_byte = rd_data[WORD_W-LANE_W*(i+1) +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= sel_byte;
  end

  assign oe = dsel && !we && !asel;
endmodule

// File: rtl/pbs_bridge.sv
module pbs_bridge #(
  parameter int unsigned LANE_W = pbs_pkg::LANE_W,
  parameter int unsigned ADDR_W = pbs_pkg::ADDR_W,
  parameter int unsigned BEATS  = pbs_pkg::BEATS
) (
  input  logic                    bus_clk,
  input  logic                    rst_n,
  input  logic                    bus_asel,
  input  logic                    bus_dsel,
  input  logic                    bus_we,
  input  logic [LANE_W-1:0]       bus_din,
  output logic [LANE_W-1:0]       bus_dout,
  output logic                    bus_oe,
  output logic                    wr_stb,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LANE_W*BEATS-1:0] wr_data,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANE_W*BEATS-1:0] rd_data
);
  localparam int unsigned BEAT_W = $clog2(BEATS);

  logic [ADDR_W-1:0] word_addr;
  logic              addr_done;
  logic              word_done;
  logic [BEAT_W-1:0] beat;

  pbs_addr_phase #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(bus_clk), .rst_n(rst_n), .asel(bus_asel), .din(bus_din),
    .inc(word_done), .word_addr(word_addr), .addr_done(addr_done));

  pbs_beat_unit #(.LANE_W(LANE_W), .ADDR_W(ADDR_W), .BEATS(BEATS)) u_beat (
    .clk(bus_clk), .rst_n(rst_n), .asel(bus_asel), .dsel(bus_dsel),
    .we(bus_we), .din(bus_din), .word_addr(word_addr), .beat(beat),
    .word_done(word_done), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data));

  pbs_lane_drv #(.LANE_W(LANE_W), .BEATS(BEATS)) u_lane (
    .clk(bus_clk), .rst_n(rst_n), .asel(bus_asel), .dsel(bus_dsel),
    .we(bus_we), .beat(beat), .rd_data(rd_data), .dout(bus_dout),
    .oe(bus_oe));

  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) rd_en <= 1'b0;
    else        rd_en <= !bus_we && (addr_done || word_done);
  end

  assign rd_addr = word_addr;

  // R10
  stb_excl_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !(wr_stb && rd_en));

  // R7
  no_drive_on_write_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    bus_we |-> !bus_oe);
endmodule

// File: tb/pbs_bridge_bench.sv
module pbs_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        asel = 1'b0, dsel = 1'b0, we = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        oe, wr_stb, rd_en;
  logic [15:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a ^ 16'hA5C3, a + 16'h1234};
  endfunction

  assign rd_data = memf(rd_addr);

  pbs_bridge u_pbs_bridge (
    .bus_clk(clk), .rst_n(rst_n), .bus_asel(asel), .bus_dsel(dsel),
    .bus_we(we), .bus_din(din), .bus_dout(dout), .bus_oe(oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  logic [15:0] m_addr = 0, m_acc = 0;
  int          m_half = 0, m_beat = 0;
  logic [31:0] m_wbuf = 0;
  logic        e_wr = 0, e_rd = 0;
  logic [15:0] e_waddr = 0;
  logic [31:0] e_wdata = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_acc = 0; m_half = 0; m_beat = 0; m_wbuf = 0;
      e_wr = 0; e_rd = 0; e_waddr = 0; e_wdata = 0;
    end else begin
      chk("R7 bus_oe", {31'd0, oe}, {31'd0, dsel && !we && !asel});
      if (dsel && !we && !asel)
        chk("R6 read byte", {24'd0, dout}, {24'd0, 8'(memf(m_addr) >> (8 * (3 - m_beat)))});
      e_wr = 0; e_rd = 0;
      if (asel) begin                       // R9: address wins
        m_beat = 0;                         // R8
        if (m_half == 1) begin
          m_addr = {m_acc[7:0], din};
          m_half = 0;
          if (!we) e_rd = 1;
        end else begin
          m_acc = {8'h00, din};
          m_half = 1;
        end
      end else begin
        m_half = 0;
        if (dsel) begin
          if (we) m_wbuf = {m_wbuf[23:0], din};
          if (m_beat == 3) begin
            if (we) begin e_wr = 1; e_wdata = m_wbuf; e_waddr = m_addr; end
            else e_rd = 1;
            m_addr = m_addr + 16'd1;
            m_beat = 0;
          end else m_beat++;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      chk("R3 wr_stb", {31'd0, wr_stb}, {31'd0, e_wr});
      if (e_wr) begin
        chk("R3 wr_data", wr_data, e_wdata);
        chk("R3 wr_addr", {16'd0, wr_addr}, {16'd0, e_waddr});
      end
      chk("R5 rd_en", {31'd0, rd_en}, {31'd0, e_rd});
      chk("R4 rd_addr", {16'd0, rd_addr}, {16'd0, m_addr});
      chk("R10 exclusive", {31'd0, wr_stb && rd_en}, 32'd0);
    end
  end

  task automatic cyc(input logic a, input logic d, input logic w, input logic [7:0] b);
    @(posedge clk); #1;
    asel = a; dsel = d; we = w; din = b;
  endtask
  task automatic idle(); cyc(1'b0, 1'b0, 1'b0, 8'h00); endtask
  task automatic addr_ph(input logic w, input logic [15:0] a);
    cyc(1'b1, 1'b0, w, a[15:8]);
    cyc(1'b1, 1'b0, w, a[7:0]);
  endtask
  task automatic wword(input logic [31:0] v);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, v[31-8*i -: 8]);
  endtask
  task automatic rword();
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 oe", {31'd0, oe}, 32'd0);
    chk("R1 wr_stb", {31'd0, wr_stb}, 32'd0);
    chk("R1 rd_en", {31'd0, rd_en}, 32'd0);
    chk("R1 rd_addr", {16'd0, rd_addr}, 32'd0);
    chk("R1 wr_data", wr_data, 32'd0);
    chk("R1 dout", {24'd0, dout}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle();
    // R2/R3 single write
    addr_ph(1'b1, 16'h1545); wword(32'hDEADBEEF); idle(); idle();
    // R5/R6 single read
    addr_ph(1'b0, 16'h0042); rword(); idle(); idle();
    // R4 burst write
    addr_ph(1'b1, 16'h0102); wword(32'hDEADBEEF); wword(32'hCAFEBABE); wword(32'hFEEDBEBE); idle();
    // R4/R6 burst read, gapless
    addr_ph(1'b0, 16'h0102); rword(); rword(); rword(); idle();
    // R4 wrap at top of address space
    addr_ph(1'b1, 16'hFFFF); wword(32'h01234567); wword(32'h89ABCDEF); idle();
    addr_ph(1'b0, 16'hFFFF); rword(); rword(); idle();
    // R8 partial write dropped by new address phase
    addr_ph(1'b1, 16'h0200);
    cyc(1'b0, 1'b1, 1'b1, 8'h11); cyc(1'b0, 1'b1, 1'b1, 8'h22);
    addr_ph(1'b1, 16'h0300); wword(32'hA1B2C3D4); idle();
    // R8 partial read dropped
    addr_ph(1'b0, 16'h0400); cyc(1'b0, 1'b1, 1'b0, 8'h00);
    addr_ph(1'b0, 16'h0500); rword(); idle();
    // R9 both strobes high: address beat
    cyc(1'b1, 1'b1, 1'b1, 8'h07); cyc(1'b1, 1'b1, 1'b1, 8'h08);
    wword(32'h5A5A0F0F); idle();
    // R2 third consecutive address beat restarts the phase
    cyc(1'b1, 1'b0, 1'b1, 8'h11); cyc(1'b1, 1'b0, 1'b1, 8'h22);
    cyc(1'b1, 1'b0, 1'b1, 8'h33); cyc(1'b1, 1'b0, 1'b1, 8'h44);
    wword(32'h0BADF00D); idle();
    // write data beats with gaps between them
    addr_ph(1'b1, 16'h0A0A);
    cyc(1'b0, 1'b1, 1'b1, 8'hC0); idle(); cyc(1'b0, 1'b1, 1'b1, 8'hFF);
    idle(); cyc(1'b0, 1'b1, 1'b1, 8'hEE); cyc(1'b0, 1'b1, 1'b1, 8'h42);
    idle(); idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule